// File: doc/BRIEF.md
# Subblocked Write-Through Cache Store Path

This block holds the tag, per-word valid bits and data of a direct-mapped cache whose lines are split into one-word subblocks. A store never triggers a block fetch. It writes its word into the line at once. If the line's tag already matches, the store only adds its word's valid bit. If the tag differs, the store claims the line: it installs its own tag and leaves only its own word marked valid. The scheme is safe only because every store also goes out on a write-through port in the same cycle, so the next memory level always holds a current copy of whatever a claimed line discards.

Reads are looked up against the line's tag and against the valid bit of the one requested word. A read result comes back one cycle after the request, flagged as a hit with data or as a miss with zero data. Refill of missing words is left to the surrounding logic.

Top module: `wt_subblock_cache`

## Requirements
- R1: A word address splits as follows. The lowest OFF_W bits select the word within the line. The next IDX_W bits select the line. The remaining upper bits form the tag. With the default parameters these fields are 2, 3 and 11 bits wide.
- R2: Reset (synchronous, active high) clears every valid bit, so any read issued after reset reports a miss.
- R3: A read is a hit when the line's tag equals the address tag and the requested word's valid bit is set. rsp_valid and rsp_hit are then high in the cycle after the request, and rsp_data holds the word last stored at that address.
- R4: A read whose tag differs or whose word is not valid sets rsp_miss, clears rsp_hit and drives rsp_data to zero in the cycle after the request.
- R5: A store whose tag matches a word that is already valid overwrites that word and leaves the valid bits of the line unchanged.
- R6: A store whose tag matches a word that is not valid writes the word and sets its valid bit. The other valid bits of the line are kept.
- R7: A store whose tag differs from the line's tag writes the word and replaces the tag. It sets the written word's valid bit and clears all other valid bits of the line, so the other words then miss under both the old tag and the new one.
- R8: Every store, hit or miss, appears on the write-through port in the same cycle as the request: wt_valid is high and wt_addr and wt_data equal the store's address and data.
- R9: A store produces no read response: rsp_valid is low in the cycle after a store.
- R10: A store changes only the line selected by its index. Every other line keeps its tag, valid bits and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Read result valid (one cycle after the read) |
| rsp_hit | output | 1 | Read found a valid word |
| rsp_miss | output | 1 | Read missed on tag or valid bit |
| rsp_data | output | DATA_W | Read data, zero on a miss |
| wt_valid | output | 1 | Store forwarded to memory |
| wt_addr | output | ADDR_W | Forwarded store address |
| wt_data | output | DATA_W | Forwarded store data |

## Verification
Stores are aimed at an empty line, at a filled word of the same tag, at an empty word of the same tag, and at a line owned by another tag. Each case is followed by reads of the written word, of its neighbours and of the old tag, which tells a tag claim apart from a simple valid-bit fill. Stores to one index are checked against reads of other lines to show lines are independent. The extreme index, offset and all-ones tag probe the address split. A store followed at once by a read of the same word exercises the one-cycle update.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [1:0] {
        STK_IDLE    = 2'd0,
        STK_REFRESH = 2'd1,
        STK_FILL    = 2'd2,
        STK_CLAIM   = 2'd3
    } store_kind_e;

    function automatic store_kind_e classify_store(
        input logic is_store,
        input logic tag_eq,
        input logic word_valid
    );
        if (!is_store)
            return STK_IDLE;
        else if (!tag_eq)
            return STK_CLAIM;
        else if (word_valid)
            return STK_REFRESH;
        else
            return STK_FILL;
    endfunction

endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
    parameter int LINES = 8,
    parameter int WORDS = 4,
    parameter int TAG_W = 11,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [TAG_W-1:0] lk_tag,
    output logic [WORDS-1:0] lk_vmask,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic [WORDS-1:0] upd_vmask
);
    logic [TAG_W-1:0]                tags_q [LINES];
    logic [LINES-1:0][WORDS-1:0]     valid_q;

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= '0;
        else if (upd_en)
            valid_q[upd_idx] <= upd_vmask;
    end

    always_ff @(posedge clk) begin
        if (upd_en)
            tags_q[upd_idx] <= upd_tag;
    end

    assign lk_tag   = tags_q[lk_idx];
    assign lk_vmask = valid_q[lk_idx];

    // R2: reset leaves no valid bit set
    assert_reset_clear_R2: assert property (@(posedge clk)
        rst |=> (valid_q == '0));

    // R7: an updated line holds the new tag and mask afterwards
    assert_line_update_R7: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> (tags_q[$past(upd_idx)] == $past(upd_tag)) &&
                   (valid_q[$past(upd_idx)] == $past(upd_vmask)));

    // R10: lines other than the updated one keep their valid bits
    assert_other_lines_R10: assert property (@(posedge clk) disable iff (rst)
        (upd_en && (lk_idx != upd_idx)) |=> (valid_q[$past(lk_idx)] == $past(lk_vmask)));
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = LINES * WORDS;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[{wr_idx, wr_off}] <= wr_data;
    end

    assign rd_data = mem_q[{rd_idx, rd_off}];

    // R5: the stored word is present in the following cycle
    assert_word_written_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem_q[{$past(wr_idx), $past(wr_off)}] == $past(wr_data)));
endmodule

// File: rtl/wtc_store_decide.sv
module wtc_store_decide
    import wtc_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int OFF_W = 2
) (
    input  logic             is_store,
    input  logic             tag_eq,
    input  logic [WORDS-1:0] cur_vmask,
    input  logic [OFF_W-1:0] off,
    output logic [WORDS-1:0] new_vmask
);
    store_kind_e kind;

    assign kind = classify_store(is_store, tag_eq, cur_vmask[off]);

    for (genvar g = 0; g < WORDS; g++) begin : g_bit
        always_comb begin
            if (OFF_W'(g) == off)
                new_vmask[g] = 1'b1;
            else if (kind == STK_CLAIM)
                new_vmask[g] = 1'b0;
            else
                new_vmask[g] = cur_vmask[g];
        end
    end

    always_comb begin
        // R6: a same-tag store keeps every bit that was already valid
        if (kind == STK_FILL || kind == STK_REFRESH)
            assert_keep_bits_R6: assert ((new_vmask & cur_vmask) == cur_vmask);
        // R7: a claiming store leaves exactly one valid word
        if (kind == STK_CLAIM)
            assert_claim_single_R7: assert ($countones(new_vmask) == 1);
    end
endmodule

// File: rtl/wt_subblock_cache.sv
module wt_subblock_cache #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int LINES  = 8,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [DATA_W-1:0] rsp_data,
    output logic              wt_valid,
    output logic [ADDR_W-1:0] wt_addr,
    output logic [DATA_W-1:0] wt_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int OFF_W = $clog2(WORDS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
    } addr_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [DATA_W-1:0] data;
    } rsp_t;

    addr_t             a;
    logic              is_store;
    logic              is_read;
    logic [TAG_W-1:0]  line_tag;
    logic [WORDS-1:0]  line_vmask;
    logic [WORDS-1:0]  next_vmask;
    logic [DATA_W-1:0] word_data;
    logic              tag_eq;
    logic              hit_now;
    rsp_t              rsp_q;

    assign a        = addr_t'(req_addr);
    assign is_store = req_valid && req_write;
    assign is_read  = req_valid && !req_write;

    wtc_tag_store #(
        .LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W), .IDX_W(IDX_W)
    ) i_tags (
        .clk      (clk),
        .rst      (rst),
        .lk_idx   (a.idx),
        .lk_tag   (line_tag),
        .lk_vmask (line_vmask),
        .upd_en   (is_store),
        .upd_idx  (a.idx),
        .upd_tag  (a.tag),
        .upd_vmask(next_vmask)
    );

    wtc_data_store #(
        .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) i_data (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (a.idx),
        .rd_off (a.off),
        .rd_data(word_data),
        .wr_en  (is_store),
        .wr_idx (a.idx),
        .wr_off (a.off),
        .wr_data(req_wdata)
    );

    assign tag_eq = (line_tag == a.tag);

    wtc_store_decide #(
        .WORDS(WORDS), .OFF_W(OFF_W)
    ) i_decide (
        .is_store (is_store),
        .tag_eq   (tag_eq),
        .cur_vmask(line_vmask),
        .off      (a.off),
        .new_vmask(next_vmask)
    );

    assign hit_now = tag_eq && line_vmask[a.off];

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= is_read;
            rsp_q.hit   <= is_read && hit_now;
            rsp_q.data  <= (is_read && hit_now) ? word_data : '0;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_miss  = rsp_q.valid && !rsp_q.hit;
    assign rsp_data  = rsp_q.data;

    assign wt_valid = is_store;
    assign wt_addr  = req_addr;
    assign wt_data  = req_wdata;

    // R3: a hit is only reported as part of a read response
    assert_hit_in_rsp_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    // R4: a miss carries no data
    assert_miss_nodata_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_data == '0));

    // R9: a store is never answered with a read response
    assert_store_silent_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> !rsp_valid);

    // R3: a read of a word just stored hits in the next cycle
    assert_store_then_read_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) ##1 (req_valid && !req_write && req_addr == $past(req_addr))
            |=> (rsp_hit && rsp_data == $past(req_wdata, 2)));
endmodule

// File: tb/test_wt_subblock_cache.sv
module test_wt_subblock_cache;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;
    localparam int LINES  = 8;
    localparam int WORDS  = 4;
    localparam int IDX_W  = 3;
    localparam int OFF_W  = 2;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr  = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid, rsp_hit, rsp_miss;
    logic [DATA_W-1:0] rsp_data;
    logic              wt_valid;
    logic [ADDR_W-1:0] wt_addr;
    logic [DATA_W-1:0] wt_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    typedef struct {
        logic              hit;
        logic [DATA_W-1:0] data;
        string             rq;
    } exp_t;
    exp_t exp_q[$];

    logic [TAG_W-1:0]  m_tag [LINES];
    logic [WORDS-1:0]  m_val [LINES];
    logic [DATA_W-1:0] m_dat [LINES][WORDS];

    wt_subblock_cache #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS)
    ) i_wt_subblock_cache (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_data(rsp_data),
        .wt_valid(wt_valid), .wt_addr(wt_addr), .wt_data(wt_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int off);
        // R1: {tag, index, offset} with the offset in the lowest bits
        return {TAG_W'(tag), IDX_W'(idx), OFF_W'(off)};
    endfunction

    task automatic do_store(input string rq, input int tag, input int idx,
                            input int off, input logic [DATA_W-1:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = mk(tag, idx, off);
        req_wdata = d;
        #1;
        check("R8", "wt_valid", 64'(wt_valid), 64'd1);
        check("R8", "wt_addr",  64'(wt_addr), 64'(mk(tag, idx, off)));
        check("R8", "wt_data",  64'(wt_data), 64'(d));
        if (m_tag[idx] != TAG_W'(tag)) begin
            m_tag[idx] = TAG_W'(tag);
            m_val[idx] = '0;
        end
        m_val[idx][off] = 1'b1;
        m_dat[idx][off] = d;
    endtask

    task automatic do_read(input string rq, input int tag, input int idx, input int off);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = mk(tag, idx, off);
        req_wdata = '0;
        e.hit  = m_val[idx][off] && (m_tag[idx] == TAG_W'(tag));
        e.data = e.hit ? m_dat[idx][off] : '0;
        e.rq   = rq;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_write = 1'b0;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R9", "unexpected rsp_valid", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.rq, "rsp_hit",  64'(rsp_hit),  64'(e.hit));
                check(e.rq, "rsp_miss", 64'(rsp_miss), 64'(!e.hit));
                check(e.rq, "rsp_data", 64'(rsp_data), 64'(e.data));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin
            m_tag[i] = '0;
            m_val[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R2: reset state of outputs
        check("R2", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R8", "wt_valid idle", 64'(wt_valid), 64'd0);

        // R2: everything misses after reset, including tag 0
        do_read("R2", 0, 0, 0);
        do_read("R2", 5, 2, 1);
        do_read("R2", 2047, 7, 3);

        // R7 on an empty line, then R3 and R4 on neighbours
        do_store("R7", 1, 2, 1, 32'hA100_0001);
        do_read("R3", 1, 2, 1);
        do_read("R4", 1, 2, 0);
        do_read("R4", 2, 2, 1);

        // R6: fill another word of the same tag
        do_store("R6", 1, 2, 3, 32'hA100_0003);
        do_read("R6", 1, 2, 3);
        do_read("R6", 1, 2, 1);
        do_read("R4", 1, 2, 2);

        // R5: overwrite a valid word
        do_store("R5", 1, 2, 1, 32'hB500_0001);
        do_read("R5", 1, 2, 1);
        do_read("R5", 1, 2, 3);

        // R10: another line is untouched by line 2
        do_store("R10", 9, 3, 0, 32'hC3C3_0000);
        do_read("R10", 1, 2, 1);
        do_read("R10", 9, 3, 0);

        // R7: a different tag claims line 2
        do_store("R7", 5, 2, 0, 32'hD700_0000);
        do_read("R7", 5, 2, 0);
        do_read("R7", 1, 2, 1);
        do_read("R7", 1, 2, 3);
        do_read("R7", 5, 2, 1);
        do_read("R10", 9, 3, 0);

        // R1: extreme index, offset and all-ones tag
        do_store("R1", 2047, 7, 3, 32'hFFFF_0073);
        do_read("R1", 2047, 7, 3);
        do_read("R1", 2047, 7, 2);
        do_read("R1", 2046, 7, 3);
        do_read("R1", 2047, 6, 3);

        // R3: read directly after a store to the same word
        do_store("R3", 12, 0, 2, 32'h1234_5678);
        do_read("R3", 12, 0, 2);
        // R9: consecutive stores, no response expected
        do_store("R9", 12, 0, 0, 32'h0000_0BAD);
        do_store("R9", 12, 0, 1, 32'h0000_0C0D);
        do_read("R6", 12, 0, 0);
        do_read("R6", 12, 0, 1);
        do_read("R6", 12, 0, 2);

        idle(4);
        check("R9", "queue drained", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule